// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets an on-chip requester use an external asynchronous static RAM that holds 1,048,576 words of 16 bits. The requester offers one access at a time over a ready/valid handshake. Each access carries a write flag, a 20-bit word address, 16 bits of write data and a 2-bit lane mask. The block answers with a one-cycle done pulse, and for reads it also returns the read data. On the memory side it generates the address, a chip-select pair made of an active-low enable and an active-high enable, the write strobe, the read strobe and two active-low byte-lane enables. The bidirectional data bus appears as three separate signals: drive value, drive enable and sampled input.

Two parameters give the clock period and the memory's address-to-data access time. From them the block works out how many cycles it must hold the address and controls stable before it samples read data or ends a write pulse. A write is framed by one setup cycle and one hold cycle, and the read strobe stays inactive for the whole write. When a write is accepted in the cycle right after a read finished, the block inserts one deselected turnaround cycle so that the controller never drives the bus while the memory may still be driving it. A request with an empty lane mask finishes at once and does not touch the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle in which reqReady is high, the memory is deselected (memCe1N=1, memCe2=0), memWeN=1, memOeN=1 and memDqOe=0. Requests are accepted only in such cycles.
- R2: memCe1N and memCe2 are always complementary. The memory is selected (memCe1N=0, memCe2=1) only while a memory read or write is in progress.
- R3: A read with a non-empty mask drives memOeN=0 and memWeN=1 for exactly WAIT = ceil(ACCESS_PS/CLK_PERIOD_PS) cycles, then samples memDqIn. rspDone is high in the cycle that follows WAIT+1 clock edges after the accepting edge. Lane i is enabled (memByteEnN[i]=0) only when mask bit i is set. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R4: In read data, a lane whose mask bit is clear reads as zero.
- R5: A write holds one setup cycle with memWeN=1, then WAIT cycles with memWeN=0, then one hold cycle with memWeN=1. The memory stays selected and the bus stays driven through all three phases. rspDone follows WAIT+3 edges after the accepting edge.
- R6: A write changes only the lanes whose mask bit is set. The other byte of the word keeps its previous value.
- R7: memDqOe is high only during the three write phases. It is never high while memOeN is low, and memOeN stays high for the whole write.
- R8: A write accepted in the cycle right after a read finished, with no idle cycle between them, gets one extra deselected cycle before the setup cycle, so rspDone follows WAIT+4 edges. A write accepted after an idle cycle with no request gets no extra cycle.
- R9: A request with mask 2'b00 completes with rspDone in the cycle after the accepting edge, without selecting the memory. When it is a read, rspData is zero. When it is a write, the memory contents do not change.
- R10: memAddr carries the full 20-bit request address and stays stable through every cycle in which the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request will be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspData | output | 16 | Read data, masked lanes zero |
| rspDone | output | 1 | One-cycle completion pulse |
| memAddr | output | 20 | Memory address |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low read strobe |
| memByteEnN | output | 2 | Active-low lane enables, bit 0 = low byte |
| memDqOut | output | 16 | Value driven onto the data bus |
| memDqOe | output | 1 | Drive enable for the data bus |
| memDqIn | input | 16 | Value sampled from the data bus |

## Verification
The assertions watch the pin protocol on every cycle. They cover the idle state, complementary chip enables, the rule that the bus is never driven while the read strobe is active, the setup and hold framing around the write strobe, the length of each strobe measured against WAIT, the turnaround before a write starts driving, and address stability while the memory is selected. Other behaviour shows up only in the bench's scenarios, which run against a memory model that returns garbage until the access time has passed. These scenarios cover: whether the correct lanes reach the array under partial masks, zeroing of unread lanes, end-to-end latency for each kind of request, the extra cycle when a write follows a read back to back, and the fact that an empty-mask request leaves the memory untouched.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // latch request fields
    logic select;      // chip selected
    logic readEn;      // output enable active
    logic writePulse;  // write strobe active
    logic driveBus;    // controller drives data bus
    logic capture;     // sample read data
    logic finish;      // completion this edge
  } ctrlStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int WAIT_CYC = 3,
  parameter int CNT_W    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqAnyLane,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  ctrlState_t       state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic             cntLoad;
  logic             prevRead;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    cntLoad   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          if (!reqAnyLane) begin
            strobe.finish = 1'b1;
          end else if (reqWrite) begin
            nextState = prevRead ? ST_TURN : ST_WSETUP;
          end else begin
            nextState = ST_READ;
            cntLoad   = 1'b1;
          end
        end
      end
      ST_READ: begin
        strobe.select = 1'b1;
        strobe.readEn = 1'b1;
        if (waitCnt == '0) begin
          strobe.capture = 1'b1;
          strobe.finish  = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_TURN: begin
        nextState = ST_WSETUP;
      end
      ST_WSETUP: begin
        strobe.select   = 1'b1;
        strobe.driveBus = 1'b1;
        cntLoad         = 1'b1;
        nextState       = ST_WPULSE;
      end
      ST_WPULSE: begin
        strobe.select     = 1'b1;
        strobe.driveBus   = 1'b1;
        strobe.writePulse = 1'b1;
        if (waitCnt == '0) nextState = ST_WHOLD;
      end
      ST_WHOLD: begin
        strobe.select   = 1'b1;
        strobe.driveBus = 1'b1;
        strobe.finish   = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      if (cntLoad)              waitCnt <= CNT_LOAD;
      else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
    end
  end

  // Remembers a read that ended with no idle gap since
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRead <= 1'b0;
    end else if (strobe.capture) begin
      prevRead <= 1'b1;
    end else if ((state == ST_IDLE && !reqValid) || state == ST_TURN) begin
      prevRead <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memByteEnN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic              zeroClear;

  assign zeroClear = strobe.loadReq & strobe.finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      maskQ   <= '0;
      rspDone <= 1'b0;
    end else begin
      rspDone <= strobe.finish;
      if (strobe.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        maskQ  <= reqMask;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memByteEnN[g] = ~(strobe.select & maskQ[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rspData[g*LANE_W +: LANE_W] <= '0;
      end else if (zeroClear) begin
        rspData[g*LANE_W +: LANE_W] <= '0;
      end else if (strobe.capture) begin
        rspData[g*LANE_W +: LANE_W] <= maskQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = strobe.driveBus;
  assign memCe1N  = ~strobe.select;
  assign memCe2   = strobe.select;
  assign memWeN   = ~strobe.writePulse;
  assign memOeN   = ~strobe.readEn;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACCESS_PS     = 10000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W/8-1:0]  reqMask,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspDone,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memCe1N,
  output logic                 memCe2,
  output logic                 memWeN,
  output logic                 memOeN,
  output logic [DATA_W/8-1:0]  memByteEnN,
  output logic [DATA_W-1:0]    memDqOut,
  output logic                 memDqOe,
  input  logic [DATA_W-1:0]    memDqIn
);

  localparam int LANES    = DATA_W / 8;
  localparam int WAIT_RAW = ceilDiv(ACCESS_PS, CLK_PERIOD_PS);
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int CNT_W    = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  ctrlStrobe_t strobe;

  sram_lane_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .CNT_W    (CNT_W)
  ) i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAnyLane (|reqMask),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  sram_lane_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqMask    (reqMask),
    .rspData    (rspData),
    .rspDone    (rspDone),
    .memAddr    (memAddr),
    .memCe1N    (memCe1N),
    .memCe2     (memCe2),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .memByteEnN (memByteEnN),
    .memDqOut   (memDqOut),
    .memDqOe    (memDqOe),
    .memDqIn    (memDqIn)
  );

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W   = 20,
  parameter int WAIT_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe
);

  int unsigned weLowRun;
  int unsigned oeLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun <= 0;
      oeLowRun <= 0;
    end else begin
      weLowRun <= memWeN ? 0 : weLowRun + 1;
      oeLowRun <= memOeN ? 0 : oeLowRun + 1;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && !memDqOe));

  assert_select_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    memCe1N != memCe2);

  assert_strobes_need_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> memCe2);

  assert_read_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowRun == WAIT_CYC));

  assert_write_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memDqOe) && $past(memCe2) && $stable(memAddr)));

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && memCe2 && $stable(memAddr) && weLowRun == WAIT_CYC));

  assert_no_bus_clash_R7: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDqOe && memWeN));

  assert_drive_only_selected_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memCe2);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> ($past(memOeN, 1) && $past(memOeN, 2)));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memCe2 && $past(memCe2)) |-> $stable(memAddr));

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W   (ADDR_W),
  .WAIT_CYC (WAIT_CYC)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .memAddr  (memAddr),
  .memCe1N  (memCe1N),
  .memCe2   (memCe2),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memDqOe  (memDqOe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CLK_PS = 4000;
  localparam int ACC_PS = 10000;
  localparam int WAITC  = (ACC_PS + CLK_PS - 1) / CLK_PS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [1:0]        reqMask = '0;
  logic [DATA_W-1:0] rspData;
  logic              rspDone;
  logic [ADDR_W-1:0] memAddr;
  logic              memCe1N, memCe2, memWeN, memOeN, memDqOe;
  logic [1:0]        memByteEnN;
  logic [DATA_W-1:0] memDqOut;
  logic [DATA_W-1:0] memDqIn;

  always #2 clk = ~clk;

  sram_lane_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_PS(CLK_PS), .ACCESS_PS(ACC_PS)
  ) i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspData(rspData), .rspDone(rspDone), .memAddr(memAddr), .memCe1N(memCe1N),
    .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN), .memByteEnN(memByteEnN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory model ----------------
  logic [15:0] memArr [int];
  logic [15:0] refMem [int];
  int          rdAge = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rdAge <= (!memOeN && !memCe1N && memCe2) ? rdAge + 1 : 0;
  end

  always @(posedge memWeN) begin
    if (!memCe1N && memCe2) begin
      logic [15:0] w;
      w = memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 16'hC3C3;
      if (!memByteEnN[0]) w[7:0]  = memDqOe ? memDqOut[7:0]  : 8'hXX;
      if (!memByteEnN[1]) w[15:8] = memDqOe ? memDqOut[15:8] : 8'hXX;
      memArr[int'(memAddr)] = w;
    end
  end

  always @(*) begin
    logic [15:0] word;
    word = memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 16'hC3C3;
    if (!memCe1N && memCe2 && !memOeN && memWeN && rdAge >= WAITC - 1) begin
      memDqIn[7:0]  = memByteEnN[0] ? 8'hEE : word[7:0];
      memDqIn[15:8] = memByteEnN[1] ? 8'hEE : word[15:8];
    end else begin
      memDqIn = 16'hBAD5;
    end
  end

  // ---------------- pin observers ----------------
  int       halfSel = 0;
  int       clashCyc = 0;
  int       selCycles = 0;
  logic [1:0] lastRdLanes = 2'b11;
  logic [1:0] lastWrLanes = 2'b11;

  always @(negedge clk) begin
    if (rstN) begin
      if (memCe1N == memCe2)      halfSel++;
      if (memDqOe && !memOeN)     clashCyc++;
      if (memCe2)                 selCycles++;
      if (!memOeN)                lastRdLanes = memByteEnN;
      if (!memWeN)                lastWrLanes = memByteEnN;
    end
  end

  // ---------------- scoreboard ----------------
  int          nChecks = 0;
  int          nFails  = 0;
  bit          doneRun = 0;
  logic [15:0] qData[$];
  bit          qChk[$];
  int          qLat[$];
  int          qAcc[$];
  string       qTag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneRun) begin
      doneRun = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic doReq(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] m, input int lat, input string tag);
    logic [15:0] old;
    logic [15:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    old = refMem.exists(int'(a)) ? refMem[int'(a)] : 16'h0000;
    exp = 16'h0000;
    if (wr) begin
      if (m[0]) old[7:0]  = d[7:0];
      if (m[1]) old[15:8] = d[15:8];
      if (m != 2'b00) refMem[int'(a)] = old;
    end else begin
      if (m[0]) exp[7:0]  = old[7:0];
      if (m[1]) exp[15:8] = old[15:8];
    end
    qData.push_back(exp);
    qChk.push_back(!wr);
    qLat.push_back(lat);
    qAcc.push_back(cyc);
    qTag.push_back(tag);
    @(posedge clk);
    reqValid <= 1'b0;
  endtask

  task automatic drain();
    while (qData.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN && rspDone) begin
      if (qData.size() == 0) begin
        check(1'b0, "R1", "unexpected done", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        bit          c;
        int          l, acc;
        string       t;
        e = qData.pop_front(); c = qChk.pop_front(); l = qLat.pop_front();
        acc = qAcc.pop_front(); t = qTag.pop_front();
        check((cyc - acc) == l, t, "latency", 32'(cyc - acc), 32'(l));
        if (c) check(rspData == e, t, "read data", 32'(rspData), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int selBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "ready after reset", 32'(reqReady), 32'd1);
    check({memCe1N, memCe2, memWeN, memOeN, memDqOe} == 5'b10110, "R1", "idle pins",
          32'({memCe1N, memCe2, memWeN, memOeN, memDqOe}), 32'b10110);
    check(rspDone == 1'b0, "R1", "no done after reset", 32'(rspDone), 32'd0);

    // R5 full write, R3 full read
    doReq(1, 20'h00000, 16'hA5C3, 2'b11, WAITC + 3, "R5");
    drain();
    doReq(0, 20'h00000, 16'h0000, 2'b11, WAITC + 1, "R3");
    drain();
    check(lastRdLanes == 2'b00, "R3", "read lanes full mask", 32'(lastRdLanes), 32'd0);

    // R10 top address, R6 partial writes
    doReq(1, 20'hFFFFF, 16'h1234, 2'b11, WAITC + 3, "R10");
    doReq(1, 20'hFFFFF, 16'hBEEF, 2'b01, WAITC + 3, "R6");
    drain();
    check(lastWrLanes == 2'b10, "R6", "write lanes low mask", 32'(lastWrLanes), 32'b10);
    doReq(1, 20'hFFFFF, 16'h7700, 2'b10, WAITC + 3, "R6");
    drain();
    doReq(0, 20'hFFFFF, 16'h0000, 2'b11, WAITC + 1, "R6");
    // R8 write straight after read
    doReq(1, 20'h00042, 16'h5A5A, 2'b11, WAITC + 4, "R8");
    drain();
    // R4 masked lane reads
    doReq(0, 20'h00042, 16'h0000, 2'b10, WAITC + 1, "R4");
    drain();
    check(lastRdLanes == 2'b01, "R3", "read lanes high mask", 32'(lastRdLanes), 32'b01);
    doReq(0, 20'hFFFFF, 16'h0000, 2'b01, WAITC + 1, "R4");
    drain();
    // R8 write after idle gap: no extra cycle
    doReq(1, 20'h00043, 16'h0F0F, 2'b11, WAITC + 3, "R8");
    drain();

    // R9 empty mask
    selBefore = selCycles;
    doReq(1, 20'h00000, 16'hFFFF, 2'b00, 1, "R9");
    drain();
    doReq(0, 20'h00000, 16'h0000, 2'b00, 1, "R9");
    drain();
    check(selCycles == selBefore, "R9", "no memory cycle", 32'(selCycles), 32'(selBefore));
    doReq(0, 20'h00000, 16'h0000, 2'b11, WAITC + 1, "R9");
    drain();

    // patterned burst
    for (int i = 0; i < 5; i++)
      doReq(1, 20'(i * 'h2345 + 7), 16'(i * 'h1357 ^ 'h8421), 2'b11, WAITC + 3, "R5");
    drain();
    for (int i = 0; i < 5; i++)
      doReq(0, 20'(i * 'h2345 + 7), 16'h0000, 2'b11, WAITC + 1, "R3");
    drain();

    check(halfSel == 0, "R2", "half-selected cycles", 32'(halfSel), 32'd0);
    check(clashCyc == 0, "R7", "drive with OE low", 32'(clashCyc), 32'd0);
    check(reqReady == 1'b1, "R1", "ready at end", 32'(reqReady), 32'd1);
    finishRun();
  end

endmodule